// File: doc/BRIEF.md
# Prescaled Core Timebase with Overflow Flag

This block is the free-running timebase of a small microcontroller. A fixed divide-by-four prescaler turns the bus clock into a count enable for an 8-bit up-counter. Software can read that counter at any moment. When the counter wraps, a sticky overflow flag is raised. If the overflow enable is also set, an interrupt request is presented to the CPU.

Software reaches the block through a one-bit register select. Select 0 is the control/status register. Bit 7 is the overflow flag, bit 6 is the overflow enable, and the other bits read as zero. Select 1 is the read-only counter register. The flag can only be cleared: software writes the status register with bit 7 at 0. Writing bit 7 as 1 leaves the flag as it is. The enable bit takes whatever bit 6 carries on every status write.

On each wrap, the block also sends a one-cycle carry pulse to the longer divider chain that follows it. Reads are combinational on the select.

Top module: `tick_timebase`

## Requirements
- R1: After reset is released, the counter first increments on the 4th rising clock edge and then on every 4th edge after that. The division ratio is fixed.
- R2: The counter is 8 bits wide and counts upward. Its value appears on rdData whenever regSel is 1, with no read strobe needed.
- R3: The overflow flag (status bit 7) sets when the counter wraps from 0xFF to 0x00. Counting from reset, this first happens on the 1024th edge.
- R4: A status write (regSel 0, wrEn 1) with bit 7 at 0 clears the flag. A status write with bit 7 at 1 leaves the flag unchanged.
- R5: irq is high exactly while both the flag and the enable (status bit 6, written by every status write) are 1.
- R6: While rst is high, the prescaler, the counter, the flag and the enable are all held at zero. rdData reads 0 for both selects, and irq and carryOut are 0.
- R7: After reset is released, counting restarts from zero, including after a reset in the middle of a run.
- R8: If a wrap and a flag-clearing write fall on the same edge, the flag ends up set.
- R9: carryOut is high for exactly one cycle per wrap: the cycle in which the counter first reads 0x00.
- R10: Writes with regSel 1 change neither the counter nor the status register.
- R11: Status bits 5 to 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| regSel | input | 1 | 0 selects status/control, 1 selects counter |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Overflow interrupt request |
| carryOut | output | 1 | One-cycle pulse on each counter wrap |

## Verification
Two events can land on the same edge: the hardware setting the flag on a wrap, and software clearing it with a status write of bit 7 at 0. The bench counts exactly 1023 edges after reset release. It then holds a clearing write so that the write is sampled on the 1024th edge, which is the edge where the counter wraps. The bench judges the outcome by reading status afterwards: the flag must still be 1. A later clearing write, away from any wrap, must still take effect.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  // Strobes sent from the register control to the datapath.
  typedef struct packed {
    logic flagWr;   // status write carries a flag field
    logic flagVal;  // value of that field (only 0 acts)
    logic enWr;     // status write updates the enable
    logic enVal;    // new enable value
  } strobe_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timebase_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int FLAG_BIT = 7,
  parameter int EN_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag,
  input  logic              en,
  output strobe_t           strb,
  output logic [DATA_W-1:0] rdData
);
  localparam logic SEL_STATUS = 1'b0;

  logic statusWr;
  assign statusWr = wrEn && (regSel == SEL_STATUS);

  always_comb begin
    strb.flagWr  = statusWr;
    strb.flagVal = wrData[FLAG_BIT];
    strb.enWr    = statusWr;
    strb.enVal   = wrData[EN_BIT];
  end

  always_comb begin
    rdData = '0;
    if (regSel == SEL_STATUS) begin
      rdData[FLAG_BIT] = flag;
      rdData[EN_BIT]   = en;
    end else begin
      rdData[CNT_W-1:0] = count;
    end
  end

  // R10: a counter-select write must never reach the datapath as a status strobe
  a_r10_no_strobe_on_count_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regSel) |-> (!strb.flagWr && !strb.enWr));
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_timebase_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             en,
  output logic             irq,
  output logic             carryOut
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic preTick;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (rst)                                 preCnt <= '0;
        else if (preCnt == PRE_W'(PRE_DIV - 1))  preCnt <= '0;
        else                                     preCnt <= preCnt + 1'b1;
      end
      assign preTick = (preCnt == PRE_W'(PRE_DIV - 1));
    end else begin : g_nopre
      assign preTick = 1'b1;
    end
  endgenerate

  logic wrap;
  assign wrap = preTick && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      carryOut <= 1'b0;
    end else begin
      if (preTick) count <= count + 1'b1;
      carryOut <= wrap;
    end
  end

  // Hardware set has priority over a software clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst)                               flag <= 1'b0;
    else if (wrap)                         flag <= 1'b1;
    else if (strb.flagWr && !strb.flagVal) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            en <= 1'b0;
    else if (strb.enWr) en <= strb.enVal;
  end

  assign irq = flag && en;

  // R9: the carry pulse never lasts two cycles
  a_r9_carry_single: assert property (@(posedge clk) disable iff (rst)
    carryOut |=> !carryOut);
  // R3 and R8: when the carry is seen, the flag is already set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    carryOut |-> flag);
  // R2: the counter only ever moves by plus one
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1)));
  // R4: writing one into the flag keeps it set
  a_r4_write_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWr && strb.flagVal && flag) |=> flag);
  // R6: the edge after reset leaves the state cleared
  a_r6_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && !flag && !en && !carryOut));
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tick_timebase_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int PRE_DIV  = 4,
  parameter int FLAG_BIT = 7,
  parameter int EN_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              carryOut
);
  strobe_t          strb;
  logic [CNT_W-1:0] count;
  logic             flag;
  logic             en;

  tick_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .FLAG_BIT(FLAG_BIT), .EN_BIT(EN_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .count(count), .flag(flag), .en(en), .strb(strb), .rdData(rdData)
  );

  tick_datapath #(
    .PRE_DIV(PRE_DIV), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .count(count), .flag(flag),
    .en(en), .irq(irq), .carryOut(carryOut)
  );
endmodule

// File: tb/sim_tick_timebase.sv
module sim_tick_timebase;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;
  logic       carryOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tick_timebase u0 (
    .clk(clk), .rst(rst), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irq(irq), .carryOut(carryOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Leaves rst low 1 ns after an edge; the next edge is edge 1 after release.
  task automatic doReset();
    rst = 1'b1; wrEn = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic readCount(output logic [7:0] v);
    regSel = 1'b1; #0.5 v = rdData;
  endtask

  task automatic readStatus(output logic [7:0] v);
    regSel = 1'b0; #0.5 v = rdData;
  endtask

  // One-edge write; consumes exactly one clock edge.
  task automatic wr(logic sel, logic [7:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    readCount(v);  check("R6 count in reset", v, 8'h00);
    readStatus(v); check("R6 status in reset", v, 8'h00);
    check("R6 irq in reset", {7'b0, irq}, 8'h00);
    check("R6 carry in reset", {7'b0, carryOut}, 8'h00);
  endtask

  task automatic tPrescale();
    logic [7:0] v;
    doReset();
    edges(3); readCount(v); check("R1 count after 3 edges", v, 8'h00);
    edges(1); readCount(v); check("R1 count after 4 edges", v, 8'h01);
    edges(4); readCount(v); check("R1 count after 8 edges", v, 8'h02);
    edges(92); readCount(v); check("R2 count after 100 edges", v, 8'd25);
  endtask

  task automatic tCountWrite();
    logic [7:0] v;
    doReset();
    edges(40);                      // count 10
    wr(1'b1, 8'h55);                // edge 41
    readCount(v);  check("R10 counter after write", v, 8'd10);
    readStatus(v); check("R10 status after counter write", v, 8'h00);
    edges(3); readCount(v); check("R10 counter keeps counting", v, 8'd11);
  endtask

  task automatic tOverflow();
    logic [7:0] v;
    doReset();
    edges(1023);
    readCount(v);  check("R3 count before wrap", v, 8'hFF);
    readStatus(v); check("R3 flag before wrap", v, 8'h00);
    check("R9 carry before wrap", {7'b0, carryOut}, 8'h00);
    edges(1);
    readCount(v);  check("R3 count after wrap", v, 8'h00);
    readStatus(v); check("R3 flag after wrap", v, 8'h80);
    check("R9 carry in wrap cycle", {7'b0, carryOut}, 8'h01);
    check("R5 irq with enable off", {7'b0, irq}, 8'h00);
    edges(1);
    check("R9 carry one cycle only", {7'b0, carryOut}, 8'h00);
    check("R11 low status bits", v & 8'h3F, 8'h00);
  endtask

  task automatic tFlagWrites();
    logic [7:0] v;
    // continues from tOverflow: flag set, enable 0
    wr(1'b0, 8'hBF);                // bit7=1 keep, bit6=0, others 1
    readStatus(v); check("R4 write one keeps flag", v, 8'h80);
    check("R11 ones in low bits read back zero", v & 8'h3F, 8'h00);
    wr(1'b0, 8'hC0);                // keep flag, enable on
    readStatus(v); check("R5 enable set", v, 8'hC0);
    check("R5 irq flag and enable", {7'b0, irq}, 8'h01);
    wr(1'b0, 8'h40);                // clear flag, keep enable
    readStatus(v); check("R4 write zero clears flag", v, 8'h40);
    check("R5 irq after clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic tIrqWait();
    logic [7:0] v;
    doReset();
    wr(1'b0, 8'h40);                // edge 1, enable on, flag stays 0
    check("R5 irq enable without flag", {7'b0, irq}, 8'h00);
    edges(1023);                    // edge 1024
    check("R5 irq raised on wrap", {7'b0, irq}, 8'h01);
    readStatus(v); check("R5 status on wrap", v, 8'hC0);
  endtask

  task automatic tCollision();
    logic [7:0] v;
    doReset();
    edges(1022);                    // edges 1..1022
    wr(1'b0, 8'h00);                // write sampled at edge 1023: no wrap yet, no-op on flag 0
    regSel = 1'b0; wrData = 8'h00; wrEn = 1'b1;
    @(posedge clk);                 // edge 1024: wrap and clear together
    #1 wrEn = 1'b0;
    readStatus(v); check("R8 set beats clear", v, 8'h80);
    readCount(v);  check("R8 count wrapped", v, 8'h00);
    wr(1'b0, 8'h00);
    readStatus(v); check("R4 later clear works", v, 8'h00);
  endtask

  task automatic tMidReset();
    logic [7:0] v;
    doReset();
    edges(6);                       // count 1, prescaler mid-way
    doReset();
    edges(3); readCount(v); check("R7 restart from zero, 3 edges", v, 8'h00);
    edges(1); readCount(v); check("R7 prescaler cleared, 4 edges", v, 8'h01);
  endtask

  initial begin
    tReset();
    tPrescale();
    tCountWrite();
    tOverflow();
    tFlagWrites();
    tIrqWait();
    tCollision();
    tMidReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule